// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block sequences the copy of a volatile SRAM image into a nonvolatile array (store) and the copy back (recall). A store can come from three sources: a software command, a hardware request pin, and an automatic request raised when a supply-low flag goes high. Each store runs as an erase phase followed by a program phase. A recall runs as a single phase. All phase lengths are set by parameters. The block drives one strobe per phase towards the array.

The sequencer keeps a dirty flag. Any SRAM write accepted while access is open sets it. Completion of a store or a recall clears it. Hardware and automatic stores only run when the flag is set. A software store runs regardless of the flag. Automatic store can be switched off and on by command. While an operation runs, the block drives an active-low busy pin and a WIP status bit, and raises an inhibit signal that the memory controller uses to block reads and writes. The supply-low flag also raises inhibit directly.

Top module: `nvcopy_seq`

## Requirements
- R1: After reset, busy_n_o is 1, and wip_o, inhibit_o (with supply_low_i low), nv_erase_o, nv_program_o and nv_recall_o are 0. Automatic store is enabled and the dirty flag is clear.
- R2: A sw_store_i pulse sampled while idle starts a store whether or not the dirty flag is set. nv_erase_o is high for exactly ERASE_CYC cycles, starting on the cycle after the pulse. nv_program_o is then high for exactly PROG_CYC cycles, and the block returns to idle.
- R3: A hw_store_req_i sampled while idle starts a store only if the dirty flag is set. Otherwise it has no effect.
- R4: A rising edge on supply_low_i sampled while idle starts a store if automatic store is enabled and the dirty flag is set. inhibit_o is high in every cycle in which supply_low_i is high, even when no store starts.
- R5: auto_off_i disables automatic store and auto_on_i enables it, starting from the next cycle. When both are high in the same cycle, disable wins. A disabled automatic request has no effect and leaves the dirty flag set.
- R6: sram_wr_i sets the dirty flag only in a cycle where inhibit_o is low. The flag clears when a store or a recall completes.
- R7: A sw_recall_i pulse sampled while idle holds nv_recall_o high for exactly RECALL_CYC cycles, starting on the next cycle, and clears the dirty flag.
- R8: While an operation runs, busy_n_o is 0, wip_o is 1, inhibit_o is 1, and exactly one of the three phase strobes is high.
- R9: Store and recall triggers sampled while an operation runs are ignored. A supply-low rising edge during an operation is held, and is qualified like a fresh automatic request on the first idle cycle.
- R10: When a store trigger and sw_recall_i arrive together while idle, the store runs and the recall is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sram_wr_i | input | 1 | An SRAM write took place this cycle |
| sw_store_i | input | 1 | Software store command pulse |
| sw_recall_i | input | 1 | Software recall command pulse |
| auto_on_i | input | 1 | Enable automatic store |
| auto_off_i | input | 1 | Disable automatic store |
| hw_store_req_i | input | 1 | Hardware store request pin, active high |
| supply_low_i | input | 1 | Supply below switch threshold |
| busy_n_o | output | 1 | Low while an operation runs |
| wip_o | output | 1 | Status bit, 1 while an operation runs |
| inhibit_o | output | 1 | Blocks memory access |
| nv_erase_o | output | 1 | Erase phase strobe to the array |
| nv_program_o | output | 1 | Program phase strobe to the array |
| nv_recall_o | output | 1 | Recall phase strobe to the array |

## Verification
The hardest case to reach is a supply-low rising edge that lands inside a running store. Handling it depends on the latched request surviving to the first idle cycle and then being judged against a dirty flag that the finishing store has just cleared. The stimulus first makes the image dirty, then starts a software store, then raises supply_low_i halfway through the erase phase. The scoreboard must see exactly one erase and program pair with no second store behind it, and inhibit_o must stay high throughout. A second hard case is proving that a disabled automatic request leaves the dirty flag set. The bench shows this by following the disabled supply drop with a hardware request that must then produce a store.

// File: rtl/nvcopy_pkg.sv
package nvcopy_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ERASE  = 2'd1,
    PH_PROG   = 2'd2,
    PH_RECALL = 2'd3
  } nv_phase_e;
endpackage

// File: rtl/nvcopy_qual.sv
module nvcopy_qual #(
  parameter bit AUTO_EN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic op_done_i,
  input  logic inhibit_i,
  input  logic sram_wr_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic hw_store_req_i,
  input  logic supply_low_i,
  input  logic auto_on_i,
  input  logic auto_off_i,
  output logic store_go_o,
  output logic recall_go_o
);
  logic dirty_q, dirty_d;
  logic auto_en_q, auto_en_d;
  logic sl_q;
  logic pend_q, pend_d;
  logic sl_rise, auto_cand, auto_go, hw_go, sw_go;

  // Trigger qualification
  always_comb begin
    sl_rise     = supply_low_i & ~sl_q;
    auto_cand   = idle_i & (sl_rise | pend_q);
    auto_go     = auto_cand & auto_en_q & dirty_q;
    hw_go       = idle_i & hw_store_req_i & dirty_q;
    sw_go       = idle_i & sw_store_i;
    store_go_o  = auto_go | hw_go | sw_go;
    recall_go_o = idle_i & sw_recall_i & ~store_go_o;
  end

  // Next-state of the tracking flags
  always_comb begin
    dirty_d = dirty_q;
    if (op_done_i) begin
      dirty_d = 1'b0;
    end else if (sram_wr_i && !inhibit_i) begin
      dirty_d = 1'b1;
    end

    auto_en_d = auto_en_q;
    if (auto_off_i) begin
      auto_en_d = 1'b0;
    end else if (auto_on_i) begin
      auto_en_d = 1'b1;
    end

    pend_d = pend_q;
    if (idle_i) begin
      pend_d = 1'b0;
    end else if (sl_rise) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q   <= 1'b0;
      auto_en_q <= AUTO_EN_RST;
      sl_q      <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      dirty_q   <= dirty_d;
      auto_en_q <= auto_en_d;
      sl_q      <= supply_low_i;
      pend_q    <= pend_d;
    end
  end

  // R3: a store from a clean image can only be the software command
  p_clean_only_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_go_o && !sw_store_i |-> dirty_q);
  // R5: a store with no software or hardware trigger needs auto enabled
  p_auto_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_go_o && !sw_store_i && !hw_store_req_i |-> auto_en_q);
  // R6: completion leaves the image clean
  p_dirty_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_done_i |=> !dirty_q);
  // R6: writes under inhibit never dirty the image
  p_no_set_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i && !dirty_q |=> !dirty_q);
  // R9: nothing starts while an operation is running
  p_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |-> !store_go_o && !recall_go_o);
endmodule

// File: rtl/nvcopy_phase.sv
module nvcopy_phase
  import nvcopy_pkg::*;
#(
  parameter int ERASE_CYC  = 8,
  parameter int PROG_CYC   = 12,
  parameter int RECALL_CYC = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      store_go_i,
  input  logic      recall_go_i,
  output nv_phase_e phase_o,
  output logic      idle_o,
  output logic      op_done_o
);
  localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAXC   = (MAX_EP > RECALL_CYC) ? MAX_EP : RECALL_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ERASE_LD  = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] PROG_LD   = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] RECALL_LD = CW'(RECALL_CYC - 1);

  nv_phase_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero, upd_en;

  always_comb begin
    cnt_zero  = (cnt_q == '0);
    st_d      = st_q;
    cnt_d     = cnt_q;
    op_done_o = 1'b0;
    case (st_q)
      PH_IDLE: begin
        if (store_go_i) begin
          st_d  = PH_ERASE;
          cnt_d = ERASE_LD;
        end else if (recall_go_i) begin
          st_d  = PH_RECALL;
          cnt_d = RECALL_LD;
        end
      end
      PH_ERASE: begin
        if (cnt_zero) begin
          st_d  = PH_PROG;
          cnt_d = PROG_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PROG, PH_RECALL: begin
        if (cnt_zero) begin
          st_d      = PH_IDLE;
          op_done_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  assign upd_en = (st_q != PH_IDLE) | store_go_i | recall_go_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = st_q;
  assign idle_o  = (st_q == PH_IDLE);

  // R2: erase is only ever followed by program
  p_erase_then_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PH_ERASE |=> st_q == PH_ERASE || st_q == PH_PROG);
  // R9: start requests only reach the sequencer when idle
  p_go_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store_go_i || recall_go_i |-> st_q == PH_IDLE);
  // R7: completion returns to idle
  p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done_o |=> st_q == PH_IDLE);
endmodule

// File: rtl/nvcopy_seq.sv
module nvcopy_seq
  import nvcopy_pkg::*;
#(
  parameter int ERASE_CYC   = 8,
  parameter int PROG_CYC    = 12,
  parameter int RECALL_CYC  = 6,
  parameter bit AUTO_EN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sram_wr_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic auto_on_i,
  input  logic auto_off_i,
  input  logic hw_store_req_i,
  input  logic supply_low_i,
  output logic busy_n_o,
  output logic wip_o,
  output logic inhibit_o,
  output logic nv_erase_o,
  output logic nv_program_o,
  output logic nv_recall_o
);
  nv_phase_e phase;
  logic idle, op_done, store_go, recall_go;

  nvcopy_qual #(.AUTO_EN_RST(AUTO_EN_RST)) u_qual (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle_i        (idle),
    .op_done_i     (op_done),
    .inhibit_i     (inhibit_o),
    .sram_wr_i     (sram_wr_i),
    .sw_store_i    (sw_store_i),
    .sw_recall_i   (sw_recall_i),
    .hw_store_req_i(hw_store_req_i),
    .supply_low_i  (supply_low_i),
    .auto_on_i     (auto_on_i),
    .auto_off_i    (auto_off_i),
    .store_go_o    (store_go),
    .recall_go_o   (recall_go)
  );

  nvcopy_phase #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_go_i (store_go),
    .recall_go_i(recall_go),
    .phase_o    (phase),
    .idle_o     (idle),
    .op_done_o  (op_done)
  );

  assign busy_n_o     = idle;
  assign wip_o        = ~idle;
  assign inhibit_o    = ~idle | supply_low_i;
  assign nv_erase_o   = (phase == PH_ERASE);
  assign nv_program_o = (phase == PH_PROG);
  assign nv_recall_o  = (phase == PH_RECALL);

  // R8: a running operation shows busy, inhibit and a single phase strobe
  p_busy_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wip_o |-> !busy_n_o && inhibit_o
              && $onehot({nv_erase_o, nv_program_o, nv_recall_o}));
  // R4: supply low always blocks access
  p_supply_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |-> inhibit_o);
  // R2: the end of erase hands straight to program
  p_prog_after_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_erase_o) |-> nv_program_o);
endmodule

// File: tb/nvcopy_seq_test.sv
module nvcopy_seq_test;
  localparam int E = 8;
  localparam int P = 12;
  localparam int R = 6;
  localparam int WD_LIMIT = 20000;

  logic clk, rst_n;
  logic sram_wr, sw_store, sw_recall, auto_on, auto_off, hw_req, supply_low;
  logic busy_n, wip, inhibit, nv_erase, nv_prog, nv_recall;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int    ph;
    int    start;
    int    len;
    string tag;
  } seg_t;
  seg_t exp_q[$];

  nvcopy_seq #(.ERASE_CYC(E), .PROG_CYC(P), .RECALL_CYC(R)) uut (
    .clk(clk), .rst_n(rst_n), .sram_wr_i(sram_wr), .sw_store_i(sw_store),
    .sw_recall_i(sw_recall), .auto_on_i(auto_on), .auto_off_i(auto_off),
    .hw_store_req_i(hw_req), .supply_low_i(supply_low), .busy_n_o(busy_n),
    .wip_o(wip), .inhibit_o(inhibit), .nv_erase_o(nv_erase),
    .nv_program_o(nv_prog), .nv_recall_o(nv_recall)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog: actual cycle=%0d expected below %0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: turns phase strobes into segments and compares with the scoreboard
  int cur_ph = 0;
  int seg_start = 0;
  always @(negedge clk) begin
    int ph;
    ph = nv_erase ? 1 : nv_prog ? 2 : nv_recall ? 3 : 0;
    if (rst_n && ph != cur_ph) begin
      if (cur_ph != 0) begin
        if (exp_q.size() == 0) begin
          chk(0, "unexpected segment", cur_ph, 0);
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          chk(e.ph == cur_ph, {e.tag, " phase"}, cur_ph, e.ph);
          chk(e.start == seg_start, {e.tag, " start"}, seg_start, e.start);
          chk(e.len == cyc - seg_start, {e.tag, " length"}, cyc - seg_start, e.len);
        end
      end
      cur_ph = ph;
      seg_start = cyc;
    end
  end

  task automatic push_store(input int s, input string tag);
    exp_q.push_back('{1, s, E, tag});
    exp_q.push_back('{2, s + E, P, tag});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one-cycle pulse; which: 0 wr,1 store,2 recall,3 on,4 off,5 hw
  task automatic pulse(input int which, output int s);
    @(negedge clk);
    case (which)
      0: sram_wr = 1;
      1: sw_store = 1;
      2: sw_recall = 1;
      3: auto_on = 1;
      4: auto_off = 1;
      default: hw_req = 1;
    endcase
    s = cyc + 1;
    @(negedge clk);
    {sram_wr, sw_store, sw_recall, auto_on, auto_off, hw_req} = '0;
  endtask

  task automatic supply_rise(output int s);
    @(negedge clk);
    supply_low = 1;
    s = cyc + 1;
    #1;
    chk(inhibit == 1, "R4 inhibit with supply low", inhibit, 1);
  endtask

  initial begin
    int s;
    rst_n = 0;
    {sram_wr, sw_store, sw_recall, auto_on, auto_off, hw_req, supply_low} = '0;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R1 reset state
    chk(busy_n == 1, "R1 busy_n", busy_n, 1);
    chk(wip == 0, "R1 wip", wip, 0);
    chk(inhibit == 0, "R1 inhibit", inhibit, 0);
    chk({nv_erase, nv_prog, nv_recall} == 0, "R1 strobes", {nv_erase, nv_prog, nv_recall}, 0);

    // R2 software store from a clean image
    pulse(1, s);
    push_store(s, "R2 sw store");
    wait_n(3);
    chk(busy_n == 0, "R8 busy_n low", busy_n, 0);
    chk(wip == 1, "R8 wip high", wip, 1);
    chk(inhibit == 1, "R8 inhibit high", inhibit, 1);
    pulse(0, s);             // R6 write under inhibit ignored
    wait_n(E + P + 4);
    pulse(5, s);             // R3 hw request on a clean image
    wait_n(E + P + 4);
    chk(wip == 0, "R3 hw clean skipped", wip, 0);

    // R6 write then hw store runs; repeat skips
    pulse(0, s);
    pulse(5, s);
    push_store(s, "R3 hw dirty store");
    wait_n(E + P + 4);
    pulse(5, s);
    wait_n(E + P + 4);
    chk(wip == 0, "R6 dirty cleared by store", wip, 0);

    // R4 supply low on a clean image: inhibit, no store
    supply_rise(s);
    wait_n(E + P + 4);
    chk(wip == 0, "R4 clean auto skipped", wip, 0);
    supply_low = 0;
    wait_n(2);
    pulse(0, s);
    supply_rise(s);
    push_store(s, "R4 auto store");
    wait_n(E + P + 4);
    supply_low = 0;
    wait_n(2);

    // R5 disabled auto keeps dirty; hw store then runs
    pulse(4, s);
    pulse(0, s);
    supply_rise(s);
    wait_n(E + P + 4);
    chk(wip == 0, "R5 auto disabled", wip, 0);
    supply_low = 0;
    wait_n(2);
    pulse(5, s);
    push_store(s, "R5 dirty kept");
    wait_n(E + P + 4);
    pulse(3, s);
    pulse(0, s);
    supply_rise(s);
    push_store(s, "R5 auto re-enabled");
    wait_n(E + P + 4);
    supply_low = 0;
    wait_n(2);

    // R7 recall clears dirty
    pulse(0, s);
    pulse(2, s);
    exp_q.push_back('{3, s, R, "R7 recall"});
    wait_n(2);
    chk(inhibit == 1, "R7 inhibit during recall", inhibit, 1);
    wait_n(R + 3);
    pulse(5, s);
    wait_n(E + P + 4);
    chk(wip == 0, "R7 dirty cleared by recall", wip, 0);

    // R9 triggers during busy ignored; supply drop latched then judged clean
    pulse(0, s);
    pulse(1, s);
    push_store(s, "R9 base store");
    wait_n(2);
    pulse(1, s);
    pulse(2, s);
    supply_rise(s);
    wait_n(E + P + 8);
    chk(wip == 0, "R9 no second store", wip, 0);
    chk(inhibit == 1, "R9 inhibit held by supply", inhibit, 1);
    supply_low = 0;
    wait_n(2);

    // R10 store beats recall in the same cycle
    @(negedge clk);
    sw_store = 1;
    sw_recall = 1;
    s = cyc + 1;
    @(negedge clk);
    {sw_store, sw_recall} = '0;
    push_store(s, "R10 store priority");
    wait_n(E + P + 6);

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule